// File: doc/BRIEF.md
# USB Host Bus Reset and High-Speed Chirp Sequencer

This block is the host-side controller that takes a freshly attached USB device through bus reset and, for a full-speed device, through the high-speed detection handshake. It does not drive the bus wires itself. Instead it asks a separate register access engine to write the PHY's function control register. One value places SE0 on the bus and arms the chirp receiver and transmitter. A later value settles the transceiver into the negotiated speed.

An attach event comes with the line state seen at attach. The block sorts the device into low-speed or full-speed, issues the reset write, and times SE0 from the cycle that write completes. During SE0 it watches the line state reported by the PHY, qualified by the high-speed differential receiver, for a sustained device chirp K. When it finds one, it sends alternating K/J chirps, switches the PHY to high-speed operation and reports high-speed. Without a chirp it restores full-speed or low-speed settings when SE0 ends and reports that speed.

Top module: `usb_host_reset_seq`

## Requirements
- R1: On `attach_vld` while idle, `attach_ls` = 2'b10 (bit1 = DM high) is classified low-speed and 2'b01 (bit0 = DP high) full-speed; 2'b00 and 2'b11 are ignored, and no write request follows.
- R2: After an accepted attach, the next cycle raises `wr_req` with `wr_addr` = 6'h04 and `wr_data` = 8'h10 (transceiver select bits [1:0] = 00, termination bit 2 = 0, operating mode bits [4:3] = 10). Address and data hold steady while `wr_req` is high and `wr_done` is low.
- R3: SE0 starts on the edge that accepts `wr_done` and lasts exactly `SE0_CYC` cycles, with no write request and no chirp during it.
- R4: A device chirp K is a cycle with `linestate` = 2'b10 and `hs_diff_k` = 1. It counts as seen after `K_MIN` consecutive such SE0 cycles, and any other cycle restarts the count.
- R5: `linestate` = 2'b10 with `hs_diff_k` = 0 is not a chirp K and leaves the outcome at full-speed.
- R6: The cycle after K is seen, `chirp_tx` goes high for 2·`CHIRP_PAIRS`·`CHIRP_LEN` cycles, with `chirp_k` high for the first `CHIRP_LEN` cycles and then alternating every `CHIRP_LEN` cycles. No write is requested while chirping.
- R7: After the chirps, a write of 8'h00 (high-speed, normal operation) is requested, and the result is high-speed.
- R8: On SE0 expiry without a chirp, a full-speed device gets a restore write of 8'h05 (select 01, termination 1, mode 00) and a low-speed device gets 8'h06 (select 10, termination 1). A low-speed device never enters chirp, whatever the line shows.
- R9: The edge that accepts `wr_done` for the final write is followed by one cycle of `speed_vld` with `speed` = 2'b00 for high-speed, 2'b01 for full-speed or 2'b10 for low-speed. `busy` is high from the accepted attach through that cycle.
- R10: When K is recognised in the last SE0 cycle, the chirp wins over expiry.
- R11: `attach_vld` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| attach_vld | input | 1 | Attach event strobe |
| attach_ls | input | 2 | Line state at attach: bit0 DP, bit1 DM |
| linestate | input | 2 | Current line state from PHY receive updates |
| hs_diff_k | input | 1 | High-speed differential receiver reports K |
| wr_done | input | 1 | Register write completed |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 6 | Register address |
| wr_data | output | 8 | Register data |
| chirp_tx | output | 1 | Host chirp transmission active |
| chirp_k | output | 1 | Current host chirp is K (else J) |
| busy | output | 1 | Sequence in progress |
| speed_vld | output | 1 | Result strobe |
| speed | output | 2 | Negotiated speed: 00 HS, 01 FS, 10 LS |

## Verification
Chirp recognition and SE0 expiry can fall in the same cycle, when the K run completes on the final SE0 cycle. The bench sweeps the start of the K run across every SE0 offset, so a complete run ends once at exactly the last cycle and once one cycle past it. The length of the quiet gap, whether chirps appear and the final write value are each compared with what is computed from `SE0_CYC` and `K_MIN`. The last-cycle case must chirp and the one-past case must fall back to full-speed.

// File: rtl/usbrs_pkg.sv
package usbrs_pkg;
  localparam logic [5:0] FCTL_ADDR = 6'h04;

  typedef enum logic [1:0] {SPD_HS = 2'b00, SPD_FS = 2'b01, SPD_LS = 2'b10} spd_e;
  typedef enum logic [2:0] {S_IDLE, S_WRST, S_SE0, S_CHIRP, S_WFIN, S_DONE} seq_st_e;

  // function control word: mode [4:3], termination [2], transceiver select [1:0]
  function automatic logic [7:0] fctl_word(input logic [1:0] xsel, input logic term,
                                           input logic [1:0] mode);
    return {3'b000, mode, term, xsel};
  endfunction

  localparam logic [7:0] W_RESET = fctl_word(2'b00, 1'b0, 2'b10);
  localparam logic [7:0] W_HS    = fctl_word(2'b00, 1'b0, 2'b00);
  localparam logic [7:0] W_FS    = fctl_word(2'b01, 1'b1, 2'b00);
  localparam logic [7:0] W_LS    = fctl_word(2'b10, 1'b1, 2'b00);
endpackage

// File: rtl/usbrs_attach_class.sv
module usbrs_attach_class (
  input  logic [1:0] ls,
  output logic       accept,
  output logic       is_low
);
  // bit1 = DM, bit0 = DP; exactly one high means a valid idle state
  always_comb begin
    accept = ls[1] ^ ls[0];
    is_low = ls[1] & ~ls[0];
  end
endmodule

// File: rtl/usbrs_cnt.sv
module usbrs_cnt #(
  parameter int MAX = 15,
  localparam int W  = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (cnt != W'(MAX))        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/usbrs_chirp_gen.sv
module usbrs_chirp_gen #(
  parameter int CHIRP_LEN   = 50,
  parameter int CHIRP_PAIRS = 3,
  localparam int NCH = 2 * CHIRP_PAIRS,
  localparam int LW  = $clog2(CHIRP_LEN + 1),
  localparam int IW  = $clog2(NCH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic tx,
  output logic is_k,
  output logic last
);
  logic [LW-1:0] len_q;
  logic [IW-1:0] idx_q;
  logic          len_end;

  assign len_end = (len_q == LW'(CHIRP_LEN - 1));
  assign last    = tx && len_end && (idx_q == IW'(NCH - 1));
  assign is_k    = tx && !idx_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= 1'b0; len_q <= '0; idx_q <= '0;
    end else if (start && !tx) begin
      tx <= 1'b1; len_q <= '0; idx_q <= '0;
    end else if (tx) begin
      if (last) tx <= 1'b0;
      if (len_end) begin
        len_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        len_q <= len_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_host_reset_seq.sv
module usb_host_reset_seq
  import usbrs_pkg::*;
#(
  parameter int SE0_CYC     = 2000,
  parameter int K_MIN       = 125,
  parameter int CHIRP_LEN   = 50,
  parameter int CHIRP_PAIRS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       attach_vld,
  input  logic [1:0] attach_ls,
  input  logic [1:0] linestate,
  input  logic       hs_diff_k,
  input  logic       wr_done,
  output logic       wr_req,
  output logic [5:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       chirp_tx,
  output logic       chirp_k,
  output logic       busy,
  output logic       speed_vld,
  output logic [1:0] speed
);
  localparam int SW = $clog2(SE0_CYC);
  localparam int KW = $clog2(K_MIN);

  seq_st_e st_q, st_d;
  spd_e    spd_q;

  // named internal events
  logic          attach_ok, attach_low;
  logic          in_se0, k_valid, k_seen, se0_expire, chirp_last, ls_mode;
  logic [SW-1:0] se0_cnt;
  logic [KW-1:0] k_cnt;

  usbrs_attach_class u_class (.ls(attach_ls), .accept(attach_ok), .is_low(attach_low));

  assign in_se0  = (st_q == S_SE0);
  assign ls_mode = (spd_q == SPD_LS);
  assign k_valid = (linestate == 2'b10) && hs_diff_k;

  usbrs_cnt #(.MAX(SE0_CYC - 1)) u_se0_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!in_se0), .cnt(se0_cnt));

  usbrs_cnt #(.MAX(K_MIN - 1)) u_k_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!in_se0 || !k_valid), .cnt(k_cnt));

  assign se0_expire = in_se0 && (se0_cnt == SW'(SE0_CYC - 1));
  assign k_seen     = in_se0 && !ls_mode && k_valid && (k_cnt == KW'(K_MIN - 1));

  usbrs_chirp_gen #(.CHIRP_LEN(CHIRP_LEN), .CHIRP_PAIRS(CHIRP_PAIRS)) u_chirp (
    .clk(clk), .rst_n(rst_n), .start(k_seen), .tx(chirp_tx), .is_k(chirp_k),
    .last(chirp_last));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (attach_vld && attach_ok) st_d = S_WRST;
      S_WRST:  if (wr_done) st_d = S_SE0;
      S_SE0:   if (k_seen) st_d = S_CHIRP;
               else if (se0_expire) st_d = S_WFIN;
      S_CHIRP: if (chirp_last) st_d = S_WFIN;
      S_WFIN:  if (wr_done) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      spd_q <= SPD_FS;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && attach_vld && attach_ok)
        spd_q <= attach_low ? SPD_LS : SPD_FS;
      else if (k_seen)
        spd_q <= SPD_HS;
    end
  end

  always_comb begin
    wr_req  = (st_q == S_WRST) || (st_q == S_WFIN);
    wr_addr = FCTL_ADDR;
    if (st_q == S_WRST)       wr_data = W_RESET;
    else if (spd_q == SPD_HS) wr_data = W_HS;
    else if (spd_q == SPD_LS) wr_data = W_LS;
    else                      wr_data = W_FS;
  end

  assign busy      = (st_q != S_IDLE);
  assign speed_vld = (st_q == S_DONE);
  assign speed     = spd_q;
endmodule

// File: rtl/usbrs_chk.sv
module usbrs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req,
  input logic       wr_done,
  input logic [5:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       chirp_tx,
  input logic       speed_vld,
  input logic       k_seen,
  input logic       se0_expire,
  input logic       ls_mode
);
  AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr == 6'h04); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_done |=> wr_req && $stable(wr_data)); // R2
  AST_NO_WR_IN_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_tx |-> !wr_req); // R6
  AST_CHIRP_AFTER_K: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chirp_tx) |-> $past(k_seen)); // R4
  AST_LS_NO_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
    k_seen |-> !ls_mode); // R8
  AST_TIE_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
    k_seen && se0_expire |=> chirp_tx && !wr_req); // R10
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    speed_vld |=> !speed_vld); // R9
endmodule

bind usb_host_reset_seq usbrs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_done(wr_done), .wr_addr(wr_addr),
  .wr_data(wr_data), .chirp_tx(chirp_tx), .speed_vld(speed_vld), .k_seen(k_seen),
  .se0_expire(se0_expire), .ls_mode(ls_mode));

// File: tb/usb_host_reset_seq_tb.sv
module usb_host_reset_seq_tb;
  localparam int SE0 = 24, KM = 4, CL = 3, CP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic attach_vld = 1'b0, hs_diff_k = 1'b0, wr_done = 1'b0;
  logic [1:0] attach_ls = 2'b00, linestate = 2'b01;
  logic wr_req, chirp_tx, chirp_k, busy, speed_vld;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] speed;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  usb_host_reset_seq #(.SE0_CYC(SE0), .K_MIN(KM), .CHIRP_LEN(CL), .CHIRP_PAIRS(CP)) u_dut (
    .clk(clk), .rst_n(rst_n), .attach_vld(attach_vld), .attach_ls(attach_ls),
    .linestate(linestate), .hs_diff_k(hs_diff_k), .wr_done(wr_done), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .chirp_tx(chirp_tx), .chirp_k(chirp_k),
    .busy(busy), .speed_vld(speed_vld), .speed(speed));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one full sequence; K run drives SE0 cycles [ks, ks+kl), diff qualifies it
  task automatic run(input logic [1:0] als, input int ks, input int kl, input bit dk,
                     input int wd, input bit late_attach);
    bit is_ls = (als == 2'b10);
    bit exp_ch = !is_ls && dk && kl >= KM && ks + KM <= SE0;
    int exp_gap = exp_ch ? ks + KM : SE0;
    int gap = 0, nch = 0;
    @(negedge clk); attach_vld = 1'b1; attach_ls = als;
    @(negedge clk); attach_vld = 1'b0;
    chk(wr_req == 1'b1, "R1 attach accepted", wr_req, 1);
    chk(busy == 1'b1, "R9 busy after attach", busy, 1);
    chk(wr_addr == 6'h04 && wr_data == 8'h10, "R2 reset word", wr_data, 8'h10);
    repeat (wd) @(negedge clk);
    chk(wr_req && wr_data == 8'h10, "R2 reset word held", wr_data, 8'h10);
    wr_done = 1'b1; @(negedge clk); wr_done = 1'b0;
    while (!wr_req && !chirp_tx) begin
      if (gap >= ks && gap < ks + kl) begin linestate = 2'b10; hs_diff_k = dk; end
      else begin linestate = 2'b01; hs_diff_k = 1'b0; end
      attach_vld = late_attach && gap == 1;
      attach_ls = 2'b10;
      @(negedge clk);
      gap++;
    end
    attach_vld = 1'b0; linestate = 2'b01; hs_diff_k = 1'b0;
    chk(gap == exp_gap, exp_ch ? "R4 R10 K recognition gap" : "R3 SE0 length", gap, exp_gap);
    chk(chirp_tx == exp_ch, is_ls ? "R8 low-speed no chirp" : "R5 chirp presence",
        chirp_tx, exp_ch);
    while (chirp_tx) begin
      chk(chirp_k == (((nch / CL) % 2) == 0) && !wr_req, "R6 chirp pattern", chirp_k,
          ((nch / CL) % 2) == 0);
      @(negedge clk);
      nch++;
    end
    if (exp_ch) chk(nch == 2 * CP * CL, "R6 chirp length", nch, 2 * CP * CL);
    begin
      int exp_w = exp_ch ? 8'h00 : (is_ls ? 8'h06 : 8'h05);
      chk(wr_req && wr_data == exp_w, exp_ch ? "R7 hs word" : "R8 restore word",
          wr_data, exp_w);
    end
    repeat (wd) @(negedge clk);
    wr_done = 1'b1; @(negedge clk); wr_done = 1'b0;
    begin
      int exp_s = exp_ch ? 0 : (is_ls ? 2 : 1);
      chk(speed_vld && speed == exp_s, late_attach ? "R11 late attach ignored" : "R9 result",
          speed, exp_s);
    end
    @(negedge clk);
    chk(!speed_vld && !busy, "R9 one-cycle result", speed_vld, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_req && !busy && !speed_vld && !chirp_tx, "R9 reset state", busy, 0);
    rst_n = 1'b1;
    // R1: invalid attach line states are ignored
    for (int v = 0; v < 4; v += 3) begin
      @(negedge clk); attach_vld = 1'b1; attach_ls = 2'(v);
      @(negedge clk); attach_vld = 1'b0;
      chk(!wr_req && !busy, "R1 invalid attach ignored", wr_req, 0);
    end
    // R4 R10: sweep K start across all SE0 offsets, tie and one-past included
    for (int ks = 0; ks <= SE0 - KM + 1; ks++) run(2'b01, ks, KM, 1'b1, ks % 3, 1'b0);
    run(2'b01, 0, KM - 1, 1'b1, 1, 1'b0);   // R4 run too short
    run(2'b01, 2, KM + 5, 1'b0, 0, 1'b0);   // R5 no diff qualification
    run(2'b10, 0, SE0, 1'b1, 2, 1'b0);      // R8 low-speed with K on the line
    run(2'b01, 30, 0, 1'b1, 1, 1'b1);       // R11 attach during SE0
    run(2'b10, 0, 0, 1'b0, 0, 1'b0);        // R8 R9 plain low-speed
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule